// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the PHY-side end of a clause 22 serial management link. The management clock and data line arrive as plain asynchronous pins. A fast system clock samples both through synchronisers and detects the edges of the management clock. The block follows the frame bit by bit: preamble, the start pair, operation code, PHY address, register address, turnaround and sixteen data bits.

A write frame hands a completed 16-bit word to a simple register-access port. A read frame fetches a word from that port and returns it on the serial line, with an output enable for a tri-state pad. The block answers for a single PHY whose 5-bit address is given on a strap input. A read aimed at any other address still returns a word, but that word is all ones and the register port is never touched. A write aimed at any other address is dropped.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: Out of reset `mdio_oe`, `mdio_out`, `proto_warn`, `reg_rd_en` and `reg_wr_en` are all 0.
- R2: A frame is recognised only when at least 32 consecutive 1s have been sampled on MDC rising edges and a 0 is then sampled. That 0 is the first start bit. A 0 that follows 31 or fewer 1s is ignored and clears the count.
- R3: After the start pair, the block samples 12 header bits MSB first on MDC rising edges: the opcode (2 bits), then the PHY address (5 bits), then the register address (5 bits). The register address appears on `reg_addr`.
- R4: Opcode 2'b10 is a read. After the second turnaround rising edge, `reg_rd_en` pulses for one clock and `mdio_oe` goes high. The 16 data bits are then driven MSB first, and `mdio_out` changes only after an MDC falling edge.
- R5: Opcode 2'b01 is a write. The block samples 16 data bits MSB first on MDC rising edges. After the 16th bit it raises exactly one `reg_wr_en` pulse, with `reg_addr` and `reg_wdata` valid in that cycle.
- R6: A read whose PHY address differs from `phy_addr` drives 16'hFFFF and produces no `reg_rd_en`.
- R7: A write whose PHY address differs from `phy_addr` produces no `reg_wr_en`.
- R8: If the second start bit is sampled as 0, the block sets `proto_warn` and decodes the frame as usual. `proto_warn` stays at 1 until reset.
- R9: At the 16th data rising edge, `mdio_oe` is released and the preamble hunt restarts with its count at zero.
- R10: Opcodes 2'b00 and 2'b11 run through the data phase with no strobe and without driving the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | 5 | Strapped address this PHY answers to |
| mdc | input | 1 | Management clock pin (asynchronous) |
| mdio_in | input | 1 | Management data pin, input side |
| mdio_out | output | 1 | Management data pin, output side |
| mdio_oe | output | 1 | Output enable for the data pad |
| reg_rd_en | output | 1 | One-clock register read strobe |
| reg_wr_en | output | 1 | One-clock register write strobe |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wdata | output | 16 | Write data, valid with `reg_wr_en` |
| reg_rdata | input | 16 | Read data, returned in the cycle of `reg_rd_en` |
| proto_warn | output | 1 | Sticky flag for a bad second start bit |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a 32-bit preamble minimum. Because of that minimum, a preamble of 31 ones and one of exactly 32 both fit inside a short run, so the edge of R2 is tested directly. A frame is also sent right after a completed one, which shows that the count restarts. MDC runs at a half period of eight system clocks. That leaves room for the three-clock path through the synchroniser and edge detector, so every data bit can be sampled late in its low phase.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int DATA_W  = 16;
    localparam int FIELD_W = 5;
    localparam int OPC_W   = 2;
    localparam int HDR_W   = OPC_W + 2 * FIELD_W;
    localparam int TA_LEN  = 2;
    localparam int CNT_W   = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START2,
        ST_HDR,
        ST_TA,
        ST_DATA
    } dec_state_e;

    typedef enum logic [1:0] {
        OP_RSVD0 = 2'b00,
        OP_WR    = 2'b01,
        OP_RD    = 2'b10,
        OP_RSVD3 = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e              op;
        logic [FIELD_W-1:0]   phy_a;
        logic [FIELD_W-1:0]   reg_a;
    } frame_hdr_t;

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_raw,
    input  logic mdio_raw,
    output logic mdio_q,
    output logic mdc_rise,
    output logic mdc_fall
);
    logic [STAGES-1:0] mdc_p;
    logic [STAGES-1:0] mdio_p;
    logic              mdc_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_p    <= '0;
            mdio_p   <= '0;
            mdc_last <= 1'b0;
        end else begin
            mdc_p    <= {mdc_p[STAGES-2:0], mdc_raw};
            mdio_p   <= {mdio_p[STAGES-2:0], mdio_raw};
            mdc_last <= mdc_p[STAGES-1];
        end
    end

    assign mdio_q   = mdio_p[STAGES-1];
    assign mdc_rise = mdc_p[STAGES-1] & ~mdc_last;
    assign mdc_fall = ~mdc_p[STAGES-1] & mdc_last;
endmodule

// File: rtl/mdio_frame_dec.sv
module mdio_frame_dec
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mdc_rise,
    input  logic                mdio_s,
    input  logic [FIELD_W-1:0]  phy_addr,
    output logic                drive,
    output logic                load,
    output logic                addr_hit,
    output logic                wr_stb,
    output logic [FIELD_W-1:0]  reg_a,
    output logic [DATA_W-1:0]   wdata,
    output logic                warn
);
    localparam int PRE_CW = $clog2(PRE_MIN + 1);
    localparam logic [PRE_CW-1:0] PRE_TOP = PRE_CW'(PRE_MIN);

    dec_state_e        state;
    frame_hdr_t        hdr;
    logic [CNT_W-1:0]  cnt;
    logic [PRE_CW-1:0] pre_cnt;
    logic [DATA_W-1:0] wd;

    assign addr_hit = (hdr.phy_a == phy_addr);
    assign reg_a    = hdr.reg_a;
    assign wdata    = wd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            hdr     <= '0;
            cnt     <= '0;
            pre_cnt <= '0;
            wd      <= '0;
            drive   <= 1'b0;
            load    <= 1'b0;
            wr_stb  <= 1'b0;
            warn    <= 1'b0;
        end else begin
            load   <= 1'b0;
            wr_stb <= 1'b0;
            if (mdc_rise) begin
                case (state)
                    ST_HUNT: begin
                        if (mdio_s) begin
                            if (pre_cnt != PRE_TOP) pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            pre_cnt <= '0;
                            if (pre_cnt == PRE_TOP) state <= ST_START2;
                        end
                    end
                    ST_START2: begin
                        if (!mdio_s) warn <= 1'b1;
                        cnt   <= '0;
                        state <= ST_HDR;
                    end
                    ST_HDR: begin
                        hdr <= frame_hdr_t'({hdr[HDR_W-2:0], mdio_s});
                        if (cnt == CNT_W'(HDR_W - 1)) begin
                            cnt   <= '0;
                            state <= ST_TA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_TA: begin
                        if (cnt == CNT_W'(TA_LEN - 1)) begin
                            cnt   <= '0;
                            state <= ST_DATA;
                            if (hdr.op == OP_RD) begin
                                drive <= 1'b1;
                                load  <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        wd <= {wd[DATA_W-2:0], mdio_s};
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            cnt     <= '0;
                            pre_cnt <= '0;
                            drive   <= 1'b0;
                            state   <= ST_HUNT;
                            if (hdr.op == OP_WR && addr_hit) wr_stb <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_rd_shift.sv
module mdio_rd_shift
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              drive,
    input  logic              mdc_fall,
    output logic              bit_out
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            sh      <= load_val;
            bit_out <= 1'b0;
        end else if (!drive) begin
            bit_out <= 1'b0;
        end else if (mdc_fall) begin
            bit_out <= sh[DATA_W-1];
            sh      <= {sh[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_mgmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_MIN     = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FIELD_W-1:0]  phy_addr,
    input  logic                mdc,
    input  logic                mdio_in,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                reg_rd_en,
    output logic                reg_wr_en,
    output logic [FIELD_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]   reg_wdata,
    input  logic [DATA_W-1:0]   reg_rdata,
    output logic                proto_warn
);
    logic mdio_s, mdc_rise, mdc_fall;
    logic drive, load, addr_hit, shift_bit;
    logic [DATA_W-1:0] load_val;

    mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc_raw  (mdc),
        .mdio_raw (mdio_in),
        .mdio_q   (mdio_s),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall)
    );

    mdio_frame_dec #(.PRE_MIN(PRE_MIN)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .mdc_rise (mdc_rise),
        .mdio_s   (mdio_s),
        .phy_addr (phy_addr),
        .drive    (drive),
        .load     (load),
        .addr_hit (addr_hit),
        .wr_stb   (reg_wr_en),
        .reg_a    (reg_addr),
        .wdata    (reg_wdata),
        .warn     (proto_warn)
    );

    assign reg_rd_en = load & addr_hit;
    assign load_val  = addr_hit ? reg_rdata : {DATA_W{1'b1}};

    mdio_rd_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .drive    (drive),
        .mdc_fall (mdc_fall),
        .bit_out  (shift_bit)
    );

    assign mdio_oe  = drive;
    assign mdio_out = shift_bit & drive;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
    input logic clk,
    input logic rst,
    input logic mdc_fall,
    input logic mdio_oe,
    input logic mdio_out,
    input logic reg_rd_en,
    input logic reg_wr_en,
    input logic proto_warn
);
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_en && reg_wr_en));

    a_r5_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    a_r4_rd_single_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> !reg_rd_en);

    a_r4_rd_with_drive: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> mdio_oe);

    a_r9_wr_line_released: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> !mdio_oe);

    a_r4_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && (mdio_out != $past(mdio_out))) |-> $past(mdc_fall));

    a_r8_warn_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_warn |=> proto_warn);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mdc_fall   (mdc_fall),
    .mdio_oe    (mdio_oe),
    .mdio_out   (mdio_out),
    .reg_rd_en  (reg_rd_en),
    .reg_wr_en  (reg_wr_en),
    .proto_warn (proto_warn)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
    localparam int HALF = 8;
    localparam logic [4:0] MY_PHY = 5'h03;

    typedef struct packed {
        logic [4:0]  a;
        logic [15:0] d;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        mdc;
    logic        mdio_in;
    logic        mdio_out, mdio_oe, reg_rd_en, reg_wr_en, proto_warn;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    logic [15:0] bank [32];
    logic [15:0] mdl  [32];
    wr_item_t    exp_q [$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          rd_cnt = 0;

    always #5 clk = ~clk;

    mdio_mgmt_slave u_mdio_mgmt_slave (
        .clk        (clk),
        .rst        (rst),
        .phy_addr   (MY_PHY),
        .mdc        (mdc),
        .mdio_in    (mdio_in),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .reg_rd_en  (reg_rd_en),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .proto_warn (proto_warn)
    );

    assign reg_rdata = bank[reg_addr];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected write items as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected write strobe", {11'd0, reg_addr, reg_wdata}, 32'd0);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check({reg_addr, reg_wdata} == {it.a, it.d}, "R5 write item",
                          {11'd0, reg_addr, reg_wdata}, {11'd0, it.a, it.d});
                end
                bank[reg_addr] = reg_wdata;
            end
            if (reg_rd_en) rd_cnt++;
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        mdio_in = b;
        repeat (HALF) @(negedge clk);
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_head(input int pre, input logic st2, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(st2);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    // driver: pushes the expected write into the scoreboard queue
    task automatic do_write(input int pre, input logic st2, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        if (pre >= 32 && op == 2'b01 && pa == MY_PHY) begin
            exp_q.push_back('{a: ra, d: d});
            mdl[ra] = d;
        end
        send_head(pre, st2, op, pa, ra);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic do_read(input int pre, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] exp, input string req);
        logic [15:0] got;
        bit oe_ok;
        oe_ok = 1'b1;
        send_head(pre, 1'b1, 2'b10, pa, ra);
        send_bit(1'b1);
        send_bit(1'b1);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            mdio_in = 1'b1;
            repeat (HALF) @(negedge clk);
            got[i] = mdio_out;
            if (!mdio_oe) oe_ok = 1'b0;
            mdc = 1'b1;
            repeat (HALF) @(negedge clk);
            mdc = 1'b0;
        end
        check(got == exp, req, {16'd0, got}, {16'd0, exp});
        check(oe_ok, "R4 enable held through data", {31'd0, oe_ok}, 32'd1);
        repeat (2) @(negedge clk);
        check(!mdio_oe, "R9 enable released after data", {31'd0, mdio_oe}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rc;
        for (int i = 0; i < 32; i++) begin
            bank[i] = 16'hA500 ^ (16'(i) * 16'h0101);
            mdl[i]  = bank[i];
        end
        rst = 1'b1;
        mdc = 1'b0;
        mdio_in = 1'b1;
        repeat (5) @(negedge clk);
        check({mdio_oe, mdio_out, proto_warn, reg_rd_en, reg_wr_en} == 5'b0, "R1 reset outputs",
              {27'd0, mdio_oe, mdio_out, proto_warn, reg_rd_en, reg_wr_en}, 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check({mdio_oe, proto_warn} == 2'b0, "R1 idle after reset", {30'd0, mdio_oe, proto_warn}, 32'd0);

        // R2 boundary of exactly 32, R3 and R5 matched write
        do_write(32, 1'b1, 2'b01, MY_PHY, 5'd5, 16'h1234);
        check(exp_q.size() == 0, "R5 R2 write strobe seen", exp_q.size(), 32'd0);

        rc = rd_cnt;
        do_read(32, MY_PHY, 5'd5, mdl[5], "R4 read back reg5");
        check(rd_cnt == rc + 1, "R4 one read strobe", rd_cnt, rc + 1);

        do_read(40, MY_PHY, 5'd31, mdl[31], "R3 read reg31 default");

        // R7 other PHY write is dropped
        do_write(32, 1'b1, 2'b01, MY_PHY ^ 5'h01, 5'd5, 16'hBEEF);
        check(exp_q.size() == 0, "R7 no pending item", exp_q.size(), 32'd0);
        do_read(32, MY_PHY, 5'd5, mdl[5], "R7 reg5 unchanged");

        // R6 other PHY read returns all ones with no strobe
        rc = rd_cnt;
        do_read(32, MY_PHY ^ 5'h10, 5'd5, 16'hFFFF, "R6 absent PHY all ones");
        check(rd_cnt == rc, "R6 no read strobe", rd_cnt, rc);

        // R2 and R9: 31 ones right after a frame must not start a frame
        do_write(31, 1'b1, 2'b01, MY_PHY, 5'd5, 16'h0F0F);
        do_read(32, MY_PHY, 5'd5, mdl[5], "R2 R9 short preamble ignored");

        // R10 reserved opcode
        do_write(32, 1'b1, 2'b00, MY_PHY, 5'd5, 16'h7777);
        check(!mdio_oe, "R10 no drive", {31'd0, mdio_oe}, 32'd0);
        do_read(32, MY_PHY, 5'd5, mdl[5], "R10 reg5 unchanged");

        // R8 bad second start bit
        check(!proto_warn, "R8 flag clear before", {31'd0, proto_warn}, 32'd0);
        do_write(32, 1'b0, 2'b01, MY_PHY, 5'd7, 16'h5A5A);
        check(proto_warn, "R8 flag set", {31'd0, proto_warn}, 32'd1);
        check(exp_q.size() == 0, "R8 frame still written", exp_q.size(), 32'd0);
        do_read(32, MY_PHY, 5'd7, mdl[7], "R8 reg7 written");
        check(proto_warn, "R8 flag sticky", {31'd0, proto_warn}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule